// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between an internal clocked bus and an external asynchronous 32K x 8 static RAM. A host presents one single-word request at a time: a direction, a 15-bit word address and, for writes, a data byte. The block holds the request in registers and drives the RAM's active-low chip enable, output enable and write enable from registers. Each timing window is a whole number of clock cycles, derived from nanosecond parameters and rounded up. For each request the block raises a one-cycle ready pulse; for a read, the fetched byte is on the read data output from that cycle on.

The RAM stores a byte only while chip enable and write enable are both low, and its data pins keep driving for a while after a read ends. The write sequence therefore has three phases. A setup cycle puts out the address and data and pulls chip enable low, with write enable still high. A pulse phase holds write enable low. A closing cycle raises both enables together and keeps the data driven. Output enable stays high for the whole write. After every read, a turnaround gap with the RAM deselected is inserted before the next access. The RAM data bus is split into an output byte, an output-drive enable and an input byte, for an external tri-state pad.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low, and afterwards until a request is accepted, mem_ce_n_o, mem_oe_n_o and mem_we_n_o are 1, mem_dq_oe_o is 0 and ready_o is 0.
- R2: A request (req_i high) is accepted only in a clock cycle where no access is in progress. we_n_req_i = 0 selects a write and 1 selects a read. Direction, address and write data are captured at acceptance; later changes to these inputs have no effect on the operation in progress.
- R3: A write drives one setup cycle (chip enable low, write enable high, data driven). Write enable is then low for WP = ceil(max(T_WP, T_RC, T_DW) / CLK_NS) cycles. A final cycle follows in which both enables are high, the data is still driven and ready_o is 1. At defaults this puts ready_o 19 cycles after chip enable falls.
- R4: Write enable is low only while chip enable is low, output enable is high and the data bus is driven. The data bus is never driven while output enable is low.
- R5: mem_addr_o changes only in cycles where write enable is high both before and after the change. mem_addr_o and mem_dq_o stay constant while write enable is low, and the data is stable for at least T_DW ns before write enable rises.
- R6: A read holds chip enable and output enable low for RD = ceil(T_RC / CLK_NS) cycles. The RAM data is registered on the last edge of that window, and ready_o is 1 in the next cycle with the byte on rdata_o. At defaults ready_o comes 18 cycles after chip enable falls.
- R7: After a read, chip enable and output enable stay high for TURN = ceil(T_TURN / CLK_NS) cycles before the next access starts. The data bus is therefore never driven within T_TURN ns of the RAM releasing it.
- R8: ready_o is high for exactly one cycle per accepted request.
- R9: A read returns the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid; held until ready_o |
| we_n_req_i | input | 1 | Request direction: 0 write, 1 read |
| addr_i | input | 15 | Request word address |
| wdata_i | input | 8 | Request write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Registered read data |
| mem_addr_o | output | 15 | RAM address |
| mem_ce_n_o | output | 1 | RAM chip enable, active low |
| mem_oe_n_o | output | 1 | RAM output enable, active low |
| mem_we_n_o | output | 1 | RAM write enable, active low |
| mem_dq_o | output | 8 | Data toward the RAM |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data from the RAM |

## Verification
The hardest cases to reach from the ports are a request whose inputs change after acceptance, and a write that starts right after a read's bus turnaround. Each operation therefore flips the address, data and direction inputs as soon as chip enable is seen low. Read and write requests are interleaved back to back over a sweep of the lowest and highest 256 addresses, walking-bit addresses and a pseudo-random stream. A behavioural RAM model in the bench timestamps every pin edge. It flags short pulses, missing data setup or hold, address motion under write enable, and drive within the RAM's release window.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RTURN
  } st_e;

  function automatic int unsigned cdiv(int unsigned n, int unsigned d);
    return (n + d - 1) / d;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_datapath.sv
`timescale 1ns/1ps
module sram_ctrl_datapath #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  // address and write data frozen from acceptance to the next acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= mem_dq_i;
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned WP_CYC   = 18,
  parameter int unsigned RD_CYC   = 18,
  parameter int unsigned TURN_CYC = 9,
  parameter int unsigned CNT_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_n_req_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ce_n_o,
  output logic             oe_n_o,
  output logic             we_n_o,
  output logic             dq_oe_o,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  st_e  state_q, state_d;
  logic ce_n_q, oe_n_q, we_n_q, dq_oe_q, ready_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (!we_n_req_i) begin
            state_d = ST_WSETUP;
          end else begin
            state_d    = ST_RACC;
            tmr_load_o = 1'b1;
            tmr_val_o  = RD_LD;
          end
        end
      end
      ST_WSETUP: begin
        state_d    = ST_WPULSE;
        tmr_load_o = 1'b1;
        tmr_val_o  = WP_LD;
      end
      ST_WPULSE: if (tmr_done_i) state_d = ST_WHOLD;
      ST_WHOLD:  state_d = ST_IDLE;
      ST_RACC: begin
        if (tmr_done_i) begin
          state_d    = ST_RTURN;
          tmr_load_o = 1'b1;
          tmr_val_o  = TURN_LD;
        end
      end
      ST_RTURN:  if (tmr_done_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign capture_o = (state_q == ST_RACC) && tmr_done_i;

  // pin levels registered from the next state: no decode glitches on the RAM strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_q  <= !(state_d inside {ST_WSETUP, ST_WPULSE, ST_RACC});
      oe_n_q  <= (state_d != ST_RACC);
      we_n_q  <= (state_d != ST_WPULSE);
      dq_oe_q <= (state_d inside {ST_WSETUP, ST_WPULSE, ST_WHOLD});
      ready_q <= (state_d == ST_WHOLD) ||
                 ((state_q == ST_RACC) && (state_d == ST_RTURN));
    end
  end

  assign ce_n_o  = ce_n_q;
  assign oe_n_o  = oe_n_q;
  assign we_n_o  = we_n_q;
  assign dq_oe_o = dq_oe_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CLK_NS = 4,
  parameter int unsigned T_RC   = 70,
  parameter int unsigned T_WP   = 50,
  parameter int unsigned T_DW   = 40,
  parameter int unsigned T_TURN = 35
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_n_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned WP_CYC   = cdiv(max2(max2(T_WP, T_RC), T_DW), CLK_NS);
  localparam int unsigned RD_CYC   = cdiv(T_RC, CLK_NS);
  localparam int unsigned TURN_CYC = max2(cdiv(T_TURN, CLK_NS), 1);
  localparam int unsigned CNT_W    = $clog2(max2(max2(WP_CYC, RD_CYC), TURN_CYC) + 1);

  logic             tmr_load, tmr_done, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  sram_ctrl_timer #(.W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_ctrl_fsm #(
    .WP_CYC   (WP_CYC),
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_n_req_i (we_n_req_i),
    .tmr_done_i (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .ce_n_o     (mem_ce_n_o),
    .oe_n_o     (mem_oe_n_o),
    .we_n_o     (mem_we_n_o),
    .dq_oe_o    (mem_dq_oe_o),
    .ready_o    (ready_o)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .capture_i  (capture),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CLK_NS = 4,
  parameter int unsigned T_RC   = 70,
  parameter int unsigned T_WP   = 50,
  parameter int unsigned T_DW   = 40,
  parameter int unsigned T_TURN = 35
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_n_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);
  localparam int unsigned TURN_SAT = (T_TURN + CLK_NS - 1) / CLK_NS;

  int unsigned we_lo_cnt, oe_lo_cnt, turn_cnt, dq_st_cnt;
  logic [DATA_W-1:0] dq_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= 0;
      oe_lo_cnt <= 0;
      turn_cnt  <= TURN_SAT;
      dq_st_cnt <= 0;
      dq_last   <= '0;
    end else begin
      we_lo_cnt <= mem_we_n_o ? 0 : we_lo_cnt + 1;
      oe_lo_cnt <= mem_oe_n_o ? 0 : oe_lo_cnt + 1;
      if (!mem_oe_n_o)             turn_cnt <= 0;
      else if (turn_cnt < TURN_SAT) turn_cnt <= turn_cnt + 1;
      dq_last <= mem_dq_o;
      if (!mem_dq_oe_o)             dq_st_cnt <= 0;
      else if (mem_dq_o != dq_last) dq_st_cnt <= 1;
      else                          dq_st_cnt <= dq_st_cnt + 1;
    end
  end

  p_we_ctl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (!mem_ce_n_o && mem_oe_n_o && mem_dq_oe_o));

  p_no_drive_on_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o);

  p_addr_move_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> (mem_we_n_o && $past(mem_we_n_o)));

  p_data_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_n_o && !$past(mem_we_n_o)) |-> ($stable(mem_dq_o) && $stable(mem_addr_o)));

  p_data_setup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (dq_st_cnt * CLK_NS >= T_DW));

  p_wp_min_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_lo_cnt * CLK_NS >= T_WP && (we_lo_cnt + 1) * CLK_NS >= T_RC));

  p_wr_close_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (mem_ce_n_o && mem_dq_oe_o && ready_o));

  p_rd_min_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_n_o) |-> (oe_lo_cnt * CLK_NS >= T_RC && ready_o));

  p_turn_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_n_o) |-> (turn_cnt * CLK_NS >= T_TURN));

  p_ready_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CLK_NS (CLK_NS),
  .T_RC   (T_RC),
  .T_WP   (T_WP),
  .T_DW   (T_DW),
  .T_TURN (T_TURN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ce_n_o  (mem_ce_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_dq_o    (mem_dq_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;
  localparam int CLK_NS = 4;
  localparam int T_RC = 70, T_WP = 50, T_DW = 40, T_TURN = 35;
  localparam int WP   = (((T_RC > T_WP) ? T_RC : T_WP) + CLK_NS - 1) / CLK_NS;
  localparam int RD   = (T_RC + CLK_NS - 1) / CLK_NS;
  localparam int WR_LAT = 1 + WP;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req = 1'b0, we_n_req = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready;
  logic [7:0]  rdata;
  logic [14:0] mem_addr;
  logic        ce_n, oe_n, we_n, dq_oe;
  logic [7:0]  dq_o, dq_i;

  int n_chk = 0, n_err = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_n_req_i(we_n_req),
    .addr_i(addr), .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata),
    .mem_addr_o(mem_addr), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n),
    .mem_we_n_o(we_n), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req_tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural RAM model ----------------
  logic [7:0] ram [int];
  logic [7:0] expv [int];
  logic ram_drv;
  time t_we_fall = 0, t_ce_fall = 0, t_dq_chg = 0, t_addr_chg = 0, t_rel = 0;

  assign ram_drv = rst_ni && !ce_n && we_n && !oe_n;

  always @(ram_drv or mem_addr) begin
    if (ram_drv) dq_i = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
    else         dq_i = 8'hzz;
  end

  always @(negedge we_n)   t_we_fall = $time;
  always @(negedge ce_n)   t_ce_fall = $time;
  always @(dq_o)           t_dq_chg  = $time;
  always @(negedge ram_drv) t_rel    = $time;
  always @(mem_addr) begin
    t_addr_chg = $time;
    if (rst_ni) chk(we_n === 1'b1, "R5", "address moved under write enable", int'(we_n), 1);
  end
  always @(posedge dq_oe)
    if (rst_ni) chk(($time - t_rel) >= T_TURN, "R7", "drive inside release window ns",
                    int'($time - t_rel), T_TURN);

  bit          wr_prev = 1'b0;
  logic [14:0] wa;
  logic [7:0]  wd;
  always @(negedge clk) begin
    bit  wr_now;
    time t_end;
    wr_now = rst_ni && !ce_n && !we_n;
    if (dq_oe && rst_ni) chk(!ram_drv, "R4", "bus contention", 1, 0);
    if (wr_prev && !wr_now) begin
      t_end = $time - CLK_NS/2;
      chk((t_end - t_we_fall) >= T_WP, "R3", "write pulse ns", int'(t_end - t_we_fall), T_WP);
      chk((t_end - t_ce_fall) >= T_RC, "R3", "chip enable to end ns", int'(t_end - t_ce_fall), T_RC);
      chk((t_end - t_addr_chg) >= T_RC, "R5", "address to end ns", int'(t_end - t_addr_chg), T_RC);
      chk((t_end - t_dq_chg) >= T_DW, "R5", "data setup ns", int'(t_end - t_dq_chg), T_DW);
      chk(dq_oe && dq_o == wd, "R3", "data hold after write", int'(dq_o), int'(wd));
      ram[int'(wa)] = wd;
    end
    if (wr_now) begin
      wa = mem_addr;
      wd = dq_o;
    end
    wr_prev = wr_now;
  end

  // ---------------- host side ----------------
  task automatic do_op(input bit is_wr, input logic [14:0] a, input logic [7:0] d);
    int lat = 0, waitc = 0;
    bit scr = 1'b0;
    @(negedge clk);
    req = 1'b1; we_n_req = !is_wr; addr = a; wdata = d;
    forever begin
      @(negedge clk);
      waitc++;
      if (ready) break;
      if (waitc > 200) begin
        chk(1'b0, "R8", "no ready", 0, 1);
        break;
      end
      if (!ce_n) begin
        lat++;
        if (!scr) begin  // R2: inputs scrambled after acceptance
          addr = ~a; wdata = ~d; we_n_req = is_wr; scr = 1'b1;
        end
      end
    end
    req = 1'b0;
    if (is_wr) begin
      chk(lat == WR_LAT, "R3", "write latency cycles", lat, WR_LAT);
      expv[int'(a)] = d;
    end else begin
      chk(lat == RD, "R6", "read latency cycles", lat, RD);
      chk(rdata == expv[int'(a)], "R9", "read data", int'(rdata), int'(expv[int'(a)]));
    end
    @(negedge clk);
    chk(!ready, "R8", "ready width", int'(ready), 0);
    chk(!is_wr || ram[int'(a)] == d, "R2", "stored byte", int'(ram[int'(a)]), int'(d));
  endtask

  function automatic logic [7:0] dgen(input logic [14:0] a, input logic [7:0] salt);
    return 8'(a * 13) ^ a[14:7] ^ salt;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && we_n && !dq_oe && !ready, "R1", "outputs in reset",
        {ce_n, oe_n, we_n, dq_oe, ready}, 5'b11100);
    rst_ni = 1'b1;
    // R1 / R2: idle with req low and inputs moving
    for (int i = 0; i < 6; i++) begin
      addr = 15'(i * 4099); we_n_req = i[0];
      @(negedge clk);
      chk(ce_n && oe_n && we_n && !dq_oe && !ready, "R1", "idle without request",
          {ce_n, oe_n, we_n, dq_oe, ready}, 5'b11100);
    end
    // sweep of lowest and highest 256 words
    for (int i = 0; i < 256; i++) do_op(1'b1, 15'(i), dgen(15'(i), 8'h00));
    for (int i = 0; i < 256; i++) do_op(1'b1, 15'(32767 - i), dgen(15'(32767 - i), 8'h3C));
    for (int i = 255; i >= 0; i--) do_op(1'b0, 15'(i), 8'h00);
    for (int i = 0; i < 256; i++) do_op(1'b0, 15'(32767 - i), 8'h00);
    // walking one and walking zero addresses
    for (int b = 0; b < 15; b++) begin
      do_op(1'b1, 15'(1 << b), dgen(15'(1 << b), 8'hA5));
      do_op(1'b1, ~15'(1 << b), dgen(~15'(1 << b), 8'h5A));
    end
    for (int b = 0; b < 15; b++) begin
      do_op(1'b0, 15'(1 << b), 8'h00);
      do_op(1'b0, ~15'(1 << b), 8'h00);
    end
    // pseudo-random write/read interleave, overwrite and read-then-write turnaround
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_op(1'b1, lfsr[14:0], lfsr[7:0] ^ 8'hC3);
      do_op(1'b0, lfsr[14:0], 8'h00);
      do_op(1'b1, lfsr[14:0], ~lfsr[15:8]);
      do_op(1'b0, lfsr[14:0], 8'h00);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule